// File: doc/BRIEF.md
# Branch Condition Resolution Unit

This unit resolves register-indirect branches for a 32-bit load/store core. Each cycle it takes the instruction's 5-bit opcode, its 3-bit condition selector, and three register values: the register under test, the branch target and the current PC. From these it decides whether the branch is taken and produces the next PC. For branch-and-link it also produces a link-register write.

The taken decision does not use status flags. The condition selector tests one general register for zero, nonzero or the state of its sign bit, and it can also force the result to always or never. Branch-and-link writes the current PC to the link register whether or not the branch is taken. The combinational results are also captured into an output register for timing. That register loads only when its clock enable is high and clears asynchronously on an active-low reset.

Top module: `branch_resolve`

## Requirements
- R1: For opcode 8 with a true condition, `next_pc` equals `target`, `taken` is 1 and `link_we` is 0.
- R2: For opcode 8 with a false condition, `next_pc` equals `pc + 4` (modulo 2^32), `taken` is 0 and `link_we` is 0.
- R3: For opcode 9, `link_we` is 1 and `link_data` equals `pc` whether or not the branch is taken. `next_pc` and `taken` follow the condition as for opcode 8.
- R4: Condition code 0 is never taken and condition code 1 is always taken.
- R5: Condition code 2 is taken when `cond_val` is zero. Condition code 3 is taken when `cond_val` is nonzero.
- R6: Condition code 4 is taken when bit 31 of `cond_val` is 0. Condition code 5 is taken when bit 31 is 1.
- R7: Condition codes 6 and 7 are never taken.
- R8: For any opcode other than 8 and 9, `next_pc` equals `pc + 4`, `taken` is 0 and `link_we` is 0.
- R9: On a rising clock edge with `en` high, each `r_` output takes the value its combinational counterpart had just before that edge.
- R10: On a rising clock edge with `en` low, every `r_` output keeps its value.
- R11: While `rst_n` is low, every `r_` output is zero, and this does not wait for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| en | input | 1 | Load enable of the output register |
| op | input | 5 | Instruction opcode |
| cond | input | 3 | Condition selector |
| cond_val | input | 32 | Value of the register under test |
| target | input | 32 | Branch target register value |
| pc | input | 32 | Current program counter |
| next_pc | output | 32 | Next program counter |
| taken | output | 1 | Branch taken |
| link_we | output | 1 | Link register write enable |
| link_data | output | 32 | Value to write to the link register |
| r_next_pc | output | 32 | Registered next_pc |
| r_taken | output | 1 | Registered taken |
| r_link_we | output | 1 | Registered link_we |
| r_link_data | output | 32 | Registered link_data |

## Verification
The assertions check several relations on every clock cycle:
- a taken branch always redirects to the target, and an untaken one always steps by four;
- a link write appears only for branch-and-link and always carries the PC;
- the spare condition codes never take;
- the output register either captures its inputs or holds, as `en` selects.

Some properties cannot be seen by a per-cycle relation, and only the bench's scenarios show them:
- that each condition code tests the right property of `cond_val` (the zero, nonzero and sign boundaries);
- that the link write happens on untaken branch-and-link;
- that reset clears the output register between clock edges.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
   // Condition selector encodings; the values are fixed by the instruction format.
   localparam int unsigned CODE_NEVER  = 0;
   localparam int unsigned CODE_ALWAYS = 1;
   localparam int unsigned CODE_ZERO   = 2;
   localparam int unsigned CODE_NONZ   = 3;
   localparam int unsigned CODE_POS    = 4;
   localparam int unsigned CODE_NEG    = 5;
   localparam int unsigned CODE_USED   = 6;

   typedef enum logic [1:0] {
      KIND_OTHER = 2'd0,
      KIND_BR    = 2'd1,
      KIND_BRL   = 2'd2
   } br_kind_e;
endpackage

// File: rtl/bcr_cond_eval.sv
module bcr_cond_eval #(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned CONDW     = 3,
   parameter int unsigned ZERO_TREE = 1,
   parameter int unsigned LEAF      = 8
) (
   input  logic [CONDW-1:0] code,
   input  logic [XLEN-1:0]  val,
   output logic             hit
);
   import bcr_pkg::*;
   localparam int unsigned NCODES = 1 << CONDW;
   localparam int unsigned NLEAF  = (XLEN + LEAF - 1) / LEAF;
   localparam int unsigned PADW   = NLEAF * LEAF;

   if (CONDW < 3) begin : g_bad_condw
      $error("bcr_cond_eval: CONDW must be at least 3");
   end
   if (XLEN < 2) begin : g_bad_xlen
      $error("bcr_cond_eval: XLEN must be at least 2");
   end
   if (LEAF < 1) begin : g_bad_leaf
      $error("bcr_cond_eval: LEAF must be at least 1");
   end

   logic is_zero;
   logic sign;
   logic [NCODES-1:0] code_hit;

   assign sign = val[XLEN-1];

   if (ZERO_TREE != 0) begin : g_tree
      logic [PADW-1:0]  padded;
      logic [NLEAF-1:0] leaf_any;
      assign padded = {{(PADW-XLEN){1'b0}}, val};
      for (genvar l = 0; l < NLEAF; l++) begin : g_leaf
         assign leaf_any[l] = |padded[l*LEAF +: LEAF];
      end
      assign is_zero = ~|leaf_any;
   end else begin : g_flat
      assign is_zero = ~|val;
   end

   for (genvar c = 0; c < NCODES; c++) begin : g_code
      if (c == CODE_ALWAYS) begin : g_al
         assign code_hit[c] = 1'b1;
      end else if (c == CODE_ZERO) begin : g_z
         assign code_hit[c] = is_zero;
      end else if (c == CODE_NONZ) begin : g_nz
         assign code_hit[c] = ~is_zero;
      end else if (c == CODE_POS) begin : g_p
         assign code_hit[c] = ~sign;
      end else if (c == CODE_NEG) begin : g_n
         assign code_hit[c] = sign;
      end else begin : g_never
         assign code_hit[c] = 1'b0;
      end
   end

   assign hit = code_hit[code];
endmodule

// File: rtl/bcr_next_pc.sv
module bcr_next_pc #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned OPW     = 5,
   parameter int unsigned OP_BR   = 8,
   parameter int unsigned OP_BRL  = 9,
   parameter int unsigned PC_STEP = 4
) (
   input  logic [OPW-1:0]  op,
   input  logic            hit,
   input  logic [XLEN-1:0] target,
   input  logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] next_pc,
   output logic            taken,
   output logic            link_we,
   output logic [XLEN-1:0] link_data
);
   import bcr_pkg::*;
   localparam logic [XLEN-1:0] STEP = XLEN'(PC_STEP);

   if (OP_BR == OP_BRL) begin : g_bad_ops
      $error("bcr_next_pc: branch opcodes must differ");
   end
   if (OP_BR >= (1 << OPW) || OP_BRL >= (1 << OPW)) begin : g_bad_opw
      $error("bcr_next_pc: opcode does not fit OPW");
   end

   br_kind_e kind;
   logic [XLEN-1:0] seq_pc;

   always_comb begin
      if (op == OPW'(OP_BR))       kind = KIND_BR;
      else if (op == OPW'(OP_BRL)) kind = KIND_BRL;
      else                         kind = KIND_OTHER;
   end

   assign seq_pc    = pc + STEP;
   assign taken     = (kind != KIND_OTHER) && hit;
   assign next_pc   = taken ? target : seq_pc;
   assign link_we   = (kind == KIND_BRL);
   assign link_data = pc;
endmodule

// File: rtl/bcr_out_reg.sv
module bcr_out_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_w
      $error("bcr_out_reg: W must be positive");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (en) q <= d;
   end
endmodule

// File: rtl/branch_resolve.sv
module branch_resolve #(
   parameter int unsigned XLEN      = 32,
   parameter int unsigned OPW       = 5,
   parameter int unsigned CONDW     = 3,
   parameter int unsigned OP_BR     = 8,
   parameter int unsigned OP_BRL    = 9,
   parameter int unsigned PC_STEP   = 4,
   parameter int unsigned ZERO_TREE = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [OPW-1:0]   op,
   input  logic [CONDW-1:0] cond,
   input  logic [XLEN-1:0]  cond_val,
   input  logic [XLEN-1:0]  target,
   input  logic [XLEN-1:0]  pc,
   output logic [XLEN-1:0]  next_pc,
   output logic             taken,
   output logic             link_we,
   output logic [XLEN-1:0]  link_data,
   output logic [XLEN-1:0]  r_next_pc,
   output logic             r_taken,
   output logic             r_link_we,
   output logic [XLEN-1:0]  r_link_data
);
   localparam int unsigned PACKW = 2 * XLEN + 2;

   logic hit;
   logic [PACKW-1:0] pack_d;
   logic [PACKW-1:0] pack_q;

   bcr_cond_eval #(
      .XLEN(XLEN), .CONDW(CONDW), .ZERO_TREE(ZERO_TREE), .LEAF(8)
   ) u_cond (
      .code(cond), .val(cond_val), .hit(hit)
   );

   bcr_next_pc #(
      .XLEN(XLEN), .OPW(OPW), .OP_BR(OP_BR), .OP_BRL(OP_BRL), .PC_STEP(PC_STEP)
   ) u_npc (
      .op(op), .hit(hit), .target(target), .pc(pc),
      .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_data(link_data)
   );

   assign pack_d = {next_pc, taken, link_we, link_data};

   bcr_out_reg #(.W(PACKW)) u_oreg (
      .clk(clk), .rst_n(rst_n), .en(en), .d(pack_d), .q(pack_q)
   );

   assign {r_next_pc, r_taken, r_link_we, r_link_data} = pack_q;
endmodule

// File: rtl/branch_resolve_chk.sv
module branch_resolve_chk #(
   parameter int unsigned XLEN    = 32,
   parameter int unsigned OPW     = 5,
   parameter int unsigned CONDW   = 3,
   parameter int unsigned OP_BRL  = 9,
   parameter int unsigned PC_STEP = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             en,
   input logic [OPW-1:0]   op,
   input logic [CONDW-1:0] cond,
   input logic [XLEN-1:0]  target,
   input logic [XLEN-1:0]  pc,
   input logic [XLEN-1:0]  next_pc,
   input logic             taken,
   input logic             link_we,
   input logic [XLEN-1:0]  link_data,
   input logic [XLEN-1:0]  r_next_pc,
   input logic             r_taken,
   input logic             r_link_we,
   input logic [XLEN-1:0]  r_link_data
);
   a_r1_taken_goes_target: assert property (@(posedge clk) disable iff (!rst_n)
      taken |-> next_pc == target);
   a_r2_untaken_steps: assert property (@(posedge clk) disable iff (!rst_n)
      !taken |-> next_pc == pc + XLEN'(PC_STEP));
   a_r3_link_only_brl: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> (op == OPW'(OP_BRL) && link_data == pc));
   a_r7_spare_never: assert property (@(posedge clk) disable iff (!rst_n)
      (cond >= CONDW'(6)) |-> !taken);
   a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> (r_next_pc == $past(next_pc) && r_taken == $past(taken)
              && r_link_we == $past(link_we) && r_link_data == $past(link_data)));
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> ($stable(r_next_pc) && $stable(r_taken)
               && $stable(r_link_we) && $stable(r_link_data)));
endmodule

bind branch_resolve branch_resolve_chk #(
   .XLEN(XLEN), .OPW(OPW), .CONDW(CONDW), .OP_BRL(OP_BRL), .PC_STEP(PC_STEP)
) u_chk (
   .clk(clk), .rst_n(rst_n), .en(en), .op(op), .cond(cond), .target(target),
   .pc(pc), .next_pc(next_pc), .taken(taken), .link_we(link_we),
   .link_data(link_data), .r_next_pc(r_next_pc), .r_taken(r_taken),
   .r_link_we(r_link_we), .r_link_data(r_link_data)
);

// File: tb/branch_resolve_tb.sv
module branch_resolve_tb;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en = 1'b0;
   logic [4:0]  op = '0;
   logic [2:0]  cond = '0;
   logic [31:0] cond_val = '0;
   logic [31:0] target = '0;
   logic [31:0] pc = '0;
   logic [31:0] next_pc, link_data, r_next_pc, r_link_data;
   logic        taken, link_we, r_taken, r_link_we;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 0;

   branch_resolve u_dut (
      .clk(clk), .rst_n(rst_n), .en(en), .op(op), .cond(cond),
      .cond_val(cond_val), .target(target), .pc(pc),
      .next_pc(next_pc), .taken(taken), .link_we(link_we), .link_data(link_data),
      .r_next_pc(r_next_pc), .r_taken(r_taken), .r_link_we(r_link_we),
      .r_link_data(r_link_data)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic bit exp_hit(input logic [2:0] c, input logic [31:0] v);
      case (c)
         3'd1: return 1'b1;
         3'd2: return v == 32'd0;
         3'd3: return v != 32'd0;
         3'd4: return v[31] == 1'b0;
         3'd5: return v[31] == 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit exp_taken(input logic [4:0] o, input logic [2:0] c,
                                    input logic [31:0] v);
      return (o == 5'd8 || o == 5'd9) && exp_hit(c, v);
   endfunction

   function automatic logic [31:0] exp_npc(input logic [4:0] o, input logic [2:0] c,
                                           input logic [31:0] v, input logic [31:0] t,
                                           input logic [31:0] p);
      return exp_taken(o, c, v) ? t : p + 32'd4;
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // Drive one vector just after a falling edge, check combinational outputs,
   // then check the output register at the following falling edge.
   task automatic apply(input string req, input logic [4:0] o, input logic [2:0] c,
                        input logic [31:0] v, input logic [31:0] t,
                        input logic [31:0] p, input bit e);
      logic [31:0] en_pc, ed;
      bit et, ew;
      logic [31:0] h_npc, h_ld;
      logic h_t, h_w;
      h_npc = r_next_pc; h_ld = r_link_data; h_t = r_taken; h_w = r_link_we;
      op = o; cond = c; cond_val = v; target = t; pc = p; en = e;
      #1;
      en_pc = exp_npc(o, c, v, t, p);
      et = exp_taken(o, c, v);
      ew = (o == 5'd9);
      ed = p;
      chk({req, " next_pc"}, next_pc, en_pc);
      chk({req, " taken"}, {31'd0, taken}, {31'd0, et});
      chk({req, " link_we"}, {31'd0, link_we}, {31'd0, ew});
      if (ew) chk({req, " link_data"}, link_data, ed);
      @(negedge clk);
      if (e) begin
         chk("R9 r_next_pc", r_next_pc, en_pc);
         chk("R9 r_taken", {31'd0, r_taken}, {31'd0, et});
         chk("R9 r_link_we", {31'd0, r_link_we}, {31'd0, ew});
         chk("R9 r_link_data", r_link_data, ed);
      end else begin
         chk("R10 r_next_pc held", r_next_pc, h_npc);
         chk("R10 r_taken held", {31'd0, r_taken}, {31'd0, h_t});
         chk("R10 r_link_we held", {31'd0, r_link_we}, {31'd0, h_w});
         chk("R10 r_link_data held", r_link_data, h_ld);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      @(negedge clk);
      @(negedge clk);
      // R11: reset state
      chk("R11 reset r_next_pc", r_next_pc, 32'd0);
      chk("R11 reset r_taken", {31'd0, r_taken}, 32'd0);
      chk("R11 reset r_link_data", r_link_data, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 / R2 / R4
      apply("R1 br always", 5'd8, 3'd1, 32'h5, 32'h0000_4000, 32'h100, 1);
      apply("R4 br never", 5'd8, 3'd0, 32'h0, 32'h0000_4000, 32'h100, 1);
      apply("R2 br false wrap", 5'd8, 3'd2, 32'h1, 32'h1234, 32'hFFFF_FFFC, 1);
      // R5 zero boundaries
      apply("R5 zero hit", 5'd8, 3'd2, 32'h0, 32'hA0, 32'h200, 1);
      apply("R5 nonzero miss", 5'd8, 3'd3, 32'h0, 32'hA0, 32'h200, 1);
      apply("R5 nonzero msb", 5'd8, 3'd3, 32'h8000_0000, 32'hA4, 32'h200, 1);
      apply("R5 nonzero lsb", 5'd8, 3'd3, 32'h1, 32'hA8, 32'h200, 1);
      // R6 sign boundaries
      apply("R6 pos max", 5'd8, 3'd4, 32'h7FFF_FFFF, 32'hB0, 32'h300, 1);
      apply("R6 pos neg", 5'd8, 3'd4, 32'h8000_0000, 32'hB0, 32'h300, 1);
      apply("R6 neg min", 5'd8, 3'd5, 32'h8000_0000, 32'hB4, 32'h300, 1);
      apply("R6 neg zero", 5'd8, 3'd5, 32'h0, 32'hB4, 32'h300, 1);
      // R7 spare codes
      apply("R7 code6", 5'd8, 3'd6, 32'h0, 32'hC0, 32'h400, 1);
      apply("R7 code7", 5'd9, 3'd7, 32'h8000_0000, 32'hC0, 32'h404, 1);
      // R3 link on taken and untaken
      apply("R3 brl taken", 5'd9, 3'd1, 32'h0, 32'hD0, 32'h500, 1);
      apply("R3 brl untaken", 5'd9, 3'd0, 32'h0, 32'hD0, 32'h504, 1);
      // R8 other opcodes
      apply("R8 op0", 5'd0, 3'd1, 32'h0, 32'hE0, 32'h600, 1);
      apply("R8 op31", 5'd31, 3'd1, 32'h0, 32'hE0, 32'h604, 1);
      apply("R8 op10", 5'd10, 3'd2, 32'h0, 32'hE0, 32'h608, 1);
      // R10 hold with en low
      apply("R10 hold", 5'd9, 3'd1, 32'h0, 32'hF0, 32'h700, 0);
      apply("R10 hold2", 5'd8, 3'd0, 32'h3, 32'hF4, 32'h704, 0);

      // Constrained random mix
      for (int i = 0; i < 400; i++) begin
         logic [4:0] ro;
         logic [31:0] rv;
         int sel;
         sel = $urandom_range(0, 3);
         ro = (sel == 0) ? 5'($urandom) : ((sel == 1) ? 5'd8 : 5'd9);
         case ($urandom_range(0, 3))
            0: rv = 32'd0;
            1: rv = 32'h8000_0000 | $urandom;
            default: rv = $urandom;
         endcase
         apply("R1 R3 random", ro, 3'($urandom), rv, $urandom & 32'hFFFF_FFFC,
               $urandom & 32'hFFFF_FFFC, ($urandom_range(0, 3) != 0));
      end

      // R11: asynchronous reset between edges
      apply("R11 preload", 5'd9, 3'd1, 32'h0, 32'h1230, 32'h800, 1);
      #(CLK_PERIOD/4);
      rst_n = 1'b0;
      #1;
      chk("R11 async r_next_pc", r_next_pc, 32'd0);
      chk("R11 async r_link_we", {31'd0, r_link_we}, 32'd0);
      chk("R11 async r_link_data", r_link_data, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      done = 1;
      finish_run();
   end
endmodule